// File: doc/BRIEF.md
# Lock Status and Observation Output Selector

This block owns one digital status pin of a dual-loop frequency synthesizer. A four-bit select word, held in the loops' reference configuration registers, decides what the pin carries. It can show whether either loop or both loops are in lock, pass through the reference-divider or main-divider pulse of either loop for observation, or command a counter reset in one or both loops. It can also pull the pin hard low as a fast-lock drive.

Lock is judged inside the block from the phase-detector up and down pulses of each loop, which are measured on a fast sampling clock. A loop counts as locked once a set number of comparison cycles (marked by its reference-divider pulse) have gone by with no wide pulse. It drops out of lock on the first wide pulse. While lock is shown, the pin sits high and dips low for as long as the observed loop's phase detector is active, which gives the expected narrow low pulses.

All inputs are sampled on `clk_i`. Every output is registered, so it reflects the inputs from the previous rising edge. The select word changes only when software reloads it, and the pins are plain level signals with no handshake.

Top module: `lock_status_mux`

## Requirements
- R1: While `rst_ni` is low, every output is 0 and both loops are treated as unlocked.
- R2: Select word 4'b0000 holds `stat_o` low. Bit 3 is the RF lock bit, bit 2 the IF lock bit, bit 1 the RF output bit and bit 0 the IF output bit.
- R3: Select 4'b1000 shows RF lock, 4'b0100 shows IF lock and 4'b1100 shows both ANDed. A shown loop contributes 1 only when it is locked and neither its up nor its down input is high, so a locked loop gives a high pin with low dips during phase-detector activity.
- R4: Select 4'b0010 passes the RF reference-divider pulse to `stat_o`, and 4'b0001 passes the IF reference-divider pulse.
- R5: Select 4'b0110 passes the RF main-divider pulse to `stat_o`, and 4'b0101 passes the IF main-divider pulse.
- R6: Select 4'b0011 drives `stat_o` low with `fastlock_oe_o` high. `fastlock_oe_o` is low for every other select value.
- R7: Select 4'b0111 asserts `if_cnt_rst_o`, 4'b1011 asserts `rf_cnt_rst_o` and 4'b1111 asserts both, with `stat_o` low. A reset stays asserted for as long as its code stays selected and drops once another code is loaded.
- R8: The select values 4'b1001, 4'b1010, 4'b1101 and 4'b1110 drive every output low.
- R9: A loop becomes locked once LOCK_CYCLES of its reference-divider pulses (counting each high sample cycle) have been sampled since reset or since its last wide pulse.
- R10: An up or down input held high for more than WIDE_MAX consecutive samples is wide and clears that loop's lock at once. A pulse of exactly WIDE_MAX samples keeps lock.
- R11: Every output has exactly one clock of latency: the value after a rising edge is set by the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Select word {RF lock, IF lock, RF out, IF out} |
| rf_ref_i | input | 1 | RF reference-divider pulse, also the RF comparison tick |
| if_ref_i | input | 1 | IF reference-divider pulse, also the IF comparison tick |
| rf_main_i | input | 1 | RF main-divider pulse |
| if_main_i | input | 1 | IF main-divider pulse |
| rf_up_i | input | 1 | RF phase-detector up pulse |
| rf_dn_i | input | 1 | RF phase-detector down pulse |
| if_up_i | input | 1 | IF phase-detector up pulse |
| if_dn_i | input | 1 | IF phase-detector down pulse |
| stat_o | output | 1 | Status pin level |
| fastlock_oe_o | output | 1 | Enable for the low-impedance pull-down |
| rf_cnt_rst_o | output | 1 | RF loop counter reset |
| if_cnt_rst_o | output | 1 | IF loop counter reset |

## Verification
The properties assume that every input is already synchronous to `clk_i`. They also assume the select word is a stable level, so that its value at one edge describes the outputs after the next. The stimulus changes inputs only on falling edges, and it loads each select code and leaves it in place for several cycles. For the lock checks it shapes the up, down and reference pulses as whole sample cycles. Pulses of exactly WIDE_MAX and WIDE_MAX+1 samples probe the edge of the width limit. The stimulus also inserts a reset before the lock sequence, so that the earlier divider pass-through patterns do not count as comparison ticks.

// File: rtl/statmux_pkg.sv
package statmux_pkg;

  typedef enum logic [2:0] {
    SHOW_OFF,
    SHOW_LOCK,
    SHOW_REF,
    SHOW_MAIN,
    SHOW_FAST,
    SHOW_RST
  } show_e;

  typedef struct packed {
    show_e kind;
    logic  use_rf;
    logic  use_if;
  } route_t;

  // sel bit 3: RF lock, bit 2: IF lock, bit 1: RF out, bit 0: IF out
  function automatic route_t decode_sel(input logic [3:0] s);
    route_t r;
    r = '{kind: SHOW_OFF, use_rf: 1'b0, use_if: 1'b0};
    case (s)
      4'b0100: r = '{kind: SHOW_LOCK, use_rf: 1'b0, use_if: 1'b1};
      4'b1000: r = '{kind: SHOW_LOCK, use_rf: 1'b1, use_if: 1'b0};
      4'b1100: r = '{kind: SHOW_LOCK, use_rf: 1'b1, use_if: 1'b1};
      4'b0001: r = '{kind: SHOW_REF,  use_rf: 1'b0, use_if: 1'b1};
      4'b0010: r = '{kind: SHOW_REF,  use_rf: 1'b1, use_if: 1'b0};
      4'b0101: r = '{kind: SHOW_MAIN, use_rf: 1'b0, use_if: 1'b1};
      4'b0110: r = '{kind: SHOW_MAIN, use_rf: 1'b1, use_if: 1'b0};
      4'b0011: r = '{kind: SHOW_FAST, use_rf: 1'b0, use_if: 1'b0};
      4'b0111: r = '{kind: SHOW_RST,  use_rf: 1'b0, use_if: 1'b1};
      4'b1011: r = '{kind: SHOW_RST,  use_rf: 1'b1, use_if: 1'b0};
      4'b1111: r = '{kind: SHOW_RST,  use_rf: 1'b1, use_if: 1'b1};
      default: r = '{kind: SHOW_OFF,  use_rf: 1'b0, use_if: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/statmux_lockdet.sv
module statmux_lockdet #(
  parameter int WIDE_MAX    = 4,
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic tick_i,
  output logic locked_o,
  output logic busy_o
);
  localparam int WW = $clog2(WIDE_MAX + 1);
  localparam int GW = $clog2(LOCK_CYCLES + 1);
  localparam logic [WW-1:0] WLIM = WW'(WIDE_MAX);
  localparam logic [GW-1:0] GLIM = GW'(LOCK_CYCLES);

  logic [WW-1:0] wcnt_q;
  logic [GW-1:0] good_q;
  logic          act;
  logic          wide;

  assign act  = up_i | dn_i;
  assign wide = act && (wcnt_q == WLIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      good_q <= '0;
    end else begin
      if (!act)       wcnt_q <= '0;
      else if (!wide) wcnt_q <= wcnt_q + 1'b1;

      if (wide)                         good_q <= '0;
      else if (tick_i && good_q != GLIM) good_q <= good_q + 1'b1;
    end
  end

  assign locked_o = (good_q == GLIM);
  assign busy_o   = act;
endmodule

// File: rtl/statmux_select.sv
module statmux_select
  import statmux_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  route_t     route_i,
  input  logic [1:0] locked_i,
  input  logic [1:0] busy_i,
  input  logic [1:0] ref_i,
  input  logic [1:0] main_i,
  output logic       stat_o,
  output logic       oe_o,
  output logic [1:0] rst_o
);
  // index 1 = RF loop, index 0 = IF loop
  logic       stat_d;
  logic       oe_d;
  logic [1:0] rst_d;
  logic [1:0] good_lvl;

  assign good_lvl = locked_i & ~busy_i;

  always_comb begin
    stat_d = 1'b0;
    oe_d   = 1'b0;
    rst_d  = 2'b00;
    case (route_i.kind)
      SHOW_LOCK: stat_d = (!route_i.use_rf || good_lvl[1]) &&
                          (!route_i.use_if || good_lvl[0]);
      SHOW_REF:  stat_d = route_i.use_rf ? ref_i[1]  : ref_i[0];
      SHOW_MAIN: stat_d = route_i.use_rf ? main_i[1] : main_i[0];
      SHOW_FAST: oe_d   = 1'b1;
      SHOW_RST:  rst_d  = {route_i.use_rf, route_i.use_if};
      default:   stat_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= 1'b0;
      oe_o   <= 1'b0;
      rst_o  <= 2'b00;
    end else begin
      stat_o <= stat_d;
      oe_o   <= oe_d;
      rst_o  <= rst_d;
    end
  end
endmodule

// File: rtl/lock_status_mux.sv
module lock_status_mux
  import statmux_pkg::*;
#(
  parameter int WIDE_MAX    = 4,
  parameter int LOCK_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sel_i,
  input  logic       rf_ref_i,
  input  logic       if_ref_i,
  input  logic       rf_main_i,
  input  logic       if_main_i,
  input  logic       rf_up_i,
  input  logic       rf_dn_i,
  input  logic       if_up_i,
  input  logic       if_dn_i,
  output logic       stat_o,
  output logic       fastlock_oe_o,
  output logic       rf_cnt_rst_o,
  output logic       if_cnt_rst_o
);
  localparam int NLOOP = 2;

  logic [NLOOP-1:0] up_v, dn_v, ref_v, main_v, locked_v, busy_v;
  logic [1:0]       rst_v;
  route_t           route;

  assign up_v   = {rf_up_i,   if_up_i};
  assign dn_v   = {rf_dn_i,   if_dn_i};
  assign ref_v  = {rf_ref_i,  if_ref_i};
  assign main_v = {rf_main_i, if_main_i};
  assign route  = decode_sel(sel_i);

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    statmux_lockdet #(
      .WIDE_MAX   (WIDE_MAX),
      .LOCK_CYCLES(LOCK_CYCLES)
    ) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .up_i    (up_v[g]),
      .dn_i    (dn_v[g]),
      .tick_i  (ref_v[g]),
      .locked_o(locked_v[g]),
      .busy_o  (busy_v[g])
    );
  end

  statmux_select u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .route_i (route),
    .locked_i(locked_v),
    .busy_i  (busy_v),
    .ref_i   (ref_v),
    .main_i  (main_v),
    .stat_o  (stat_o),
    .oe_o    (fastlock_oe_o),
    .rst_o   (rst_v)
  );

  assign rf_cnt_rst_o = rst_v[1];
  assign if_cnt_rst_o = rst_v[0];
endmodule

// File: rtl/lock_status_mux_chk.sv
module lock_status_mux_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] sel_i,
  input logic       rf_ref_i,
  input logic       if_main_i,
  input logic       stat_o,
  input logic       fastlock_oe_o,
  input logic       rf_cnt_rst_o,
  input logic       if_cnt_rst_o
);
  // R6
  fast_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fastlock_oe_o |-> !stat_o);

  // R2
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0000) |=> !stat_o);

  // R4
  rf_ref_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0010) |=> (stat_o == $past(rf_ref_i)));

  // R5
  if_main_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0101) |=> (stat_o == $past(if_main_i)));

  // R7
  rf_rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b1011 || sel_i == 4'b1111) |=> (rf_cnt_rst_o && !stat_o));

  // R7
  if_rst_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i == 4'b0111 || sel_i == 4'b1111) |=> !if_cnt_rst_o);

  // R8
  unused_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b1001 || sel_i == 4'b1010 || sel_i == 4'b1101 || sel_i == 4'b1110)
    |=> !(stat_o || fastlock_oe_o || rf_cnt_rst_o || if_cnt_rst_o));

  // R6
  fast_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 4'b0011) |=> !fastlock_oe_o);
endmodule

bind lock_status_mux lock_status_mux_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .rf_ref_i     (rf_ref_i),
  .if_main_i    (if_main_i),
  .stat_o       (stat_o),
  .fastlock_oe_o(fastlock_oe_o),
  .rf_cnt_rst_o (rf_cnt_rst_o),
  .if_cnt_rst_o (if_cnt_rst_o)
);

// File: tb/sim_lock_status_mux.sv
module sim_lock_status_mux;
  localparam int CLK_P    = 10;
  localparam int WIDE_MAX = 4;
  localparam int LOCKS    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = 4'b0000;
  logic rf_ref = 0, if_ref = 0, rf_main = 0, if_main = 0;
  logic rf_up = 0, rf_dn = 0, if_up = 0, if_dn = 0;
  logic stat, oe, rf_rst, if_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [3:0] v;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  lock_status_mux #(.WIDE_MAX(WIDE_MAX), .LOCK_CYCLES(LOCKS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel),
    .rf_ref_i(rf_ref), .if_ref_i(if_ref), .rf_main_i(rf_main), .if_main_i(if_main),
    .rf_up_i(rf_up), .rf_dn_i(rf_dn), .if_up_i(if_up), .if_dn_i(if_dn),
    .stat_o(stat), .fastlock_oe_o(oe), .rf_cnt_rst_o(rf_rst), .if_cnt_rst_o(if_rst)
  );

  // monitor: one expected item per falling edge, compared just after it
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ({stat, oe, rf_rst, if_rst} !== e.v) begin
        n_fail++;
        $display("FAIL %s: {stat,oe,rf_rst,if_rst} actual=%b expected=%b",
                 e.tag, {stat, oe, rf_rst, if_rst}, e.v);
      end
    end
  end

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [3:0] v);
    exp_t e;
    e.tag = tag;
    e.v   = v;
    q.push_back(e);
  endtask

  task automatic load(input logic [3:0] s, input string tag, input logic [3:0] v);
    sel = s;
    go(2);
    expect_out(tag, v);
  endtask

  task automatic rf_tick();
    rf_ref = 1; go(1); rf_ref = 0; go(2);
  endtask

  task automatic if_tick();
    if_ref = 1; go(1); if_ref = 0; go(2);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    go(3);
    expect_out("R1 reset state", 4'b0000);
    go(1);
    rst_n = 1;

    // R2: disabled code with every source high
    rf_ref = 1; if_ref = 1; rf_main = 1; if_main = 1;
    load(4'b0000, "R2 disabled", 4'b0000);

    // R4: reference dividers
    if_ref = 0;
    load(4'b0010, "R4 rf ref high", 4'b1000);
    load(4'b0001, "R4 if ref low", 4'b0000);
    rf_ref = 0; if_ref = 1;
    load(4'b0001, "R4 if ref high", 4'b1000);

    // R5: main dividers
    rf_main = 1; if_main = 0;
    load(4'b0110, "R5 rf main high", 4'b1000);
    load(4'b0101, "R5 if main low", 4'b0000);

    // R11: one-cycle latency on a toggling source
    sel = 4'b0010;
    go(2);
    for (int i = 0; i < 6; i++) begin
      rf_ref = i[0];
      go(1);
      expect_out("R11 latency", {i[0], 3'b000});
    end

    // R6: fast-lock drive
    rf_ref = 1; if_ref = 1;
    load(4'b0011, "R6 fast lock", 4'b0100);

    // R7: counter resets
    load(4'b0111, "R7 if reset", 4'b0001);
    load(4'b1011, "R7 rf reset", 4'b0010);
    load(4'b1111, "R7 both reset", 4'b0011);
    go(5);
    expect_out("R7 reset held", 4'b0011);
    load(4'b0000, "R7 reset released", 4'b0000);

    // R8: unlisted codes with all sources high
    rf_main = 1; if_main = 1;
    begin
      logic [3:0] odd [4] = '{4'b1001, 4'b1010, 4'b1101, 4'b1110};
      foreach (odd[k]) load(odd[k], "R8 unlisted code", 4'b0000);
    end

    // fresh start for the lock sequence
    rf_ref = 0; if_ref = 0; rf_main = 0; if_main = 0;
    sel = 4'b0000;
    rst_n = 0;
    go(2);
    rst_n = 1;

    // R9: RF acquisition
    load(4'b1000, "R9 rf not locked after reset", 4'b0000);
    for (int i = 0; i < LOCKS - 1; i++) rf_tick();
    expect_out("R9 rf one tick short", 4'b0000);
    rf_tick();
    expect_out("R9 rf locked", 4'b1000);

    // R3: lock views with only RF locked
    load(4'b0100, "R3 if view unlocked", 4'b0000);
    load(4'b1100, "R3 both view one unlocked", 4'b0000);
    for (int i = 0; i < LOCKS; i++) if_tick();
    load(4'b1100, "R3 both locked", 4'b1000);
    load(4'b0100, "R3 if view locked", 4'b1000);

    // R3 / R10: narrow pulse dips the pin but keeps lock
    sel = 4'b1100;
    go(2);
    if_up = 1;
    go(1);
    expect_out("R3 narrow low dip", 4'b0000);
    go(WIDE_MAX - 1);
    if_up = 0;
    go(2);
    expect_out("R10 pulse at limit keeps lock", 4'b1000);

    // R10: wide pulse clears RF lock
    sel = 4'b1000;
    go(2);
    rf_dn = 1;
    go(WIDE_MAX + 1);
    rf_dn = 0;
    go(2);
    expect_out("R10 wide pulse drops rf lock", 4'b0000);
    load(4'b0100, "R10 if lock unaffected", 4'b1000);

    // R9: re-acquire RF after loss
    sel = 4'b1000;
    for (int i = 0; i < LOCKS; i++) rf_tick();
    expect_out("R9 rf relocked", 4'b1000);

    while (q.size() > 0) go(1);
    go(2);
    done = 1;
    report();
  end
endmodule